// File: doc/BRIEF.md
# Soft-Decision Quantizer and Branch Metric Generator

This block sits at the front of a Viterbi decoder for a rate-1/2, constraint-length-7 convolutional code with generators 133 and 171 (octal). Each trellis step it takes one pair of received BPSK samples as signed fixed-point numbers. It clips each sample to a selectable limit and maps it onto a fixed number of offset-binary soft levels. From the two soft values it forms the four branch metrics for the codeword hypotheses 00, 01, 10 and 11. The metrics leave through a registered valid strobe, ready for the add-compare-select stage.

The clip limit is chosen per step. It sits either on the nominal constellation points (±1.0) or beyond them (±2.0). In both cases the clipped range is split into the same 2^SOFT_W levels. A separate combinational lookup gives the two encoder output bits that belong to any branch of the 64-state trellis, so the path-metric logic can pair each branch with its metric.

Top module: `sdq_branch_metrics`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, out_valid is 0 and all four metrics read 0.
- R2: out_valid equals in_valid of the previous clock cycle. Back-to-back valid inputs produce back-to-back valid outputs with no gaps.
- R3: With clip_wide = 0 the limit L is 1.0, which is 2^FRAC in raw units. Each sample x maps to q = floor((x + L)·2^SOFT_W / (2L)), saturated to the range 0 .. 2^SOFT_W−1. Any x ≤ −L gives 0 and any x ≥ +L gives the all-ones code.
- R4: With clip_wide = 1 the limit L is 2.0 (2^(FRAC+1) raw), and the same formula and the same 2^SOFT_W levels apply.
- R5: A transmitted bit 1 corresponds to +1.0, so the all-ones code means a confident 1 and code 0 means a confident 0. The distance of q from hypothesis bit 0 is q, and from hypothesis bit 1 it is (2^SOFT_W−1)−q.
- R6: bm_xy is the distance of sample_a's code from bit x plus the distance of sample_b's code from bit y. sample_a carries the generator-133 bit. Each metric is SOFT_W+1 bits wide.
- R7: Whenever out_valid is 1, bm_00 + bm_11 and bm_01 + bm_10 both equal 2·(2^SOFT_W−1).
- R8: A cycle with in_valid low leaves all four metrics unchanged, whatever values the sample inputs carry.
- R9: The branch label is computed on a 7-bit window {lbl_input, lbl_state[5:0]}. lbl_input is the current input, lbl_state[5] is the most recent earlier input and lbl_state[0] is the oldest. lbl_code[1] is the parity of the window masked with 133 octal, and lbl_code[0] is the parity masked with 171 octal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample pair is present this cycle |
| clip_wide | input | 1 | 0: clip at ±1.0, 1: clip at ±2.0 |
| sample_a | input | IN_W | Signed sample for the generator-133 bit, FRAC fraction bits |
| sample_b | input | IN_W | Signed sample for the generator-171 bit, FRAC fraction bits |
| out_valid | output | 1 | Metrics are valid this cycle |
| bm_00 | output | SOFT_W+1 | Metric for hypothesis 00 |
| bm_01 | output | SOFT_W+1 | Metric for hypothesis 01 |
| bm_10 | output | SOFT_W+1 | Metric for hypothesis 10 |
| bm_11 | output | SOFT_W+1 | Metric for hypothesis 11 |
| lbl_state | input | K−1 | Trellis state for the label lookup |
| lbl_input | input | 1 | Input bit of the branch |
| lbl_code | output | 2 | Encoder output bits of that branch |

## Verification
The only state in this block is the metric register and the valid flag, so a fault shows at the ports on the very next cycle. A wrong step size, offset or saturation point changes the metric sums for particular sample values in the sweep. A missing hold enable shows up as metrics that drift during idle cycles. A swapped hypothesis or lane shows up as a broken complement-pair sum or a transposed metric. A tap error in the label logic mislabels at least one of the 128 branches, and every branch is checked.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
   // Number of hypotheses for a rate-1/2 code
   localparam int NUM_HYP = 4;

   // Parity of a tap-masked window
   function automatic logic tap_parity(input logic [31:0] window, input logic [31:0] poly);
      return ^(window & poly);
   endfunction
endpackage

// File: rtl/sdq_lane.sv
module sdq_lane #(
   parameter int IN_W   = 8,
   parameter int FRAC   = 4,
   parameter int SOFT_W = 4
) (
   input  logic signed [IN_W-1:0] x,
   input  logic                   wide,
   output logic [SOFT_W-1:0]      q
);
   localparam int EW   = IN_W + 3;
   localparam int QMAX = (1 << SOFT_W) - 1;
   localparam int SH0  = FRAC + 1 - SOFT_W;

   logic signed [EW-1:0] xe;
   logic signed [EW-1:0] lim;
   logic signed [EW-1:0] t;
   logic signed [EW-1:0] s;

   always_comb begin
      xe  = {{3{x[IN_W-1]}}, x};
      lim = wide ? EW'(2 << FRAC) : EW'(1 << FRAC);
      t   = xe + lim;
      s   = wide ? (t >>> (SH0 + 1)) : (t >>> SH0);
      if (t < 0)
         q = '0;
      else if (s > EW'(QMAX))
         q = SOFT_W'(QMAX);
      else
         q = s[SOFT_W-1:0];
   end
endmodule

// File: rtl/sdq_metric.sv
module sdq_metric #(
   parameter int SOFT_W = 4,
   localparam int BW    = SOFT_W + 1
) (
   input  logic [SOFT_W-1:0]                   q_a,
   input  logic [SOFT_W-1:0]                   q_b,
   output logic [sdq_pkg::NUM_HYP-1:0][BW-1:0] bm
);
   localparam logic [SOFT_W-1:0] QMAX = '1;

   for (genvar h = 0; h < sdq_pkg::NUM_HYP; h++) begin : g_hyp
      localparam logic [1:0] HB = 2'(h);
      logic [SOFT_W-1:0] d_a;
      logic [SOFT_W-1:0] d_b;
      assign d_a   = HB[1] ? (QMAX - q_a) : q_a;
      assign d_b   = HB[0] ? (QMAX - q_b) : q_b;
      assign bm[h] = BW'(d_a) + BW'(d_b);
   end
endmodule

// File: rtl/sdq_branch_label.sv
module sdq_branch_label #(
   parameter int          K  = 7,
   parameter logic [31:0] G0 = 32'o133,
   parameter logic [31:0] G1 = 32'o171
) (
   input  logic [K-2:0] st,
   input  logic         u,
   output logic [1:0]   code
);
   logic [31:0] window;
   assign window = 32'({u, st});

   for (genvar p = 0; p < 2; p++) begin : g_poly
      localparam logic [31:0] POLY = (p == 1) ? G0 : G1;
      assign code[p] = sdq_pkg::tap_parity(window, POLY);
   end
endmodule

// File: rtl/sdq_branch_metrics.sv
module sdq_branch_metrics #(
   parameter int          IN_W   = 8,
   parameter int          FRAC   = 4,
   parameter int          SOFT_W = 4,
   parameter int          K      = 7,
   parameter logic [31:0] G0     = 32'o133,
   parameter logic [31:0] G1     = 32'o171
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic                   clip_wide,
   input  logic signed [IN_W-1:0] sample_a,
   input  logic signed [IN_W-1:0] sample_b,
   output logic                   out_valid,
   output logic [SOFT_W:0]        bm_00,
   output logic [SOFT_W:0]        bm_01,
   output logic [SOFT_W:0]        bm_10,
   output logic [SOFT_W:0]        bm_11,
   input  logic [K-2:0]           lbl_state,
   input  logic                   lbl_input,
   output logic [1:0]             lbl_code
);
   localparam int BW = SOFT_W + 1;

   if (SOFT_W < 2) begin : g_chk_soft
      $error("SOFT_W must be at least 2");
   end
   if (FRAC + 1 < SOFT_W) begin : g_chk_frac
      $error("FRAC+1 must be at least SOFT_W");
   end
   if (IN_W < FRAC + 3) begin : g_chk_inw
      $error("IN_W must hold +/-2.0");
   end
   if (K < 3 || K > 31) begin : g_chk_k
      $error("K out of range");
   end

   logic [1:0][IN_W-1:0]   lane_x;
   logic [1:0][SOFT_W-1:0] lane_q;
   assign lane_x[0] = sample_a;
   assign lane_x[1] = sample_b;

   for (genvar l = 0; l < 2; l++) begin : g_lane
      sdq_lane #(.IN_W(IN_W), .FRAC(FRAC), .SOFT_W(SOFT_W)) lane_i (
         .x    (lane_x[l]),
         .wide (clip_wide),
         .q    (lane_q[l])
      );
   end

   logic [sdq_pkg::NUM_HYP-1:0][BW-1:0] bm_next;
   logic [sdq_pkg::NUM_HYP-1:0][BW-1:0] bm_q;

   sdq_metric #(.SOFT_W(SOFT_W)) metric_i (
      .q_a (lane_q[0]),
      .q_b (lane_q[1]),
      .bm  (bm_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         bm_q      <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            bm_q <= bm_next;
      end
   end

   assign bm_00 = bm_q[0];
   assign bm_01 = bm_q[1];
   assign bm_10 = bm_q[2];
   assign bm_11 = bm_q[3];

   sdq_branch_label #(.K(K), .G0(G0), .G1(G1)) label_i (
      .st   (lbl_state),
      .u    (lbl_input),
      .code (lbl_code)
   );
endmodule

// File: rtl/sdq_bm_checker.sv
module sdq_bm_checker #(
   parameter int SOFT_W = 4,
   parameter int K      = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          out_valid,
   input logic [SOFT_W:0] bm_00,
   input logic [SOFT_W:0] bm_01,
   input logic [SOFT_W:0] bm_10,
   input logic [SOFT_W:0] bm_11,
   input logic [K-2:0]  lbl_state,
   input logic          lbl_input,
   input logic [1:0]    lbl_code
);
   localparam int PAIR = 2 * ((1 << SOFT_W) - 1);

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R2
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(bm_00) && $stable(bm_01) && $stable(bm_10) && $stable(bm_11))); // R8
   AST_PAIR_SUM_A: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (32'(bm_00) + 32'(bm_11) == PAIR)); // R7
   AST_PAIR_SUM_B: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (32'(bm_01) + 32'(bm_10) == PAIR)); // R7
   AST_ZERO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
      (lbl_state == '0 && !lbl_input) |-> (lbl_code == 2'b00)); // R9
endmodule

bind sdq_branch_metrics sdq_bm_checker #(.SOFT_W(SOFT_W), .K(K)) chk_i (.*);

// File: tb/sdq_branch_metrics_tb_top.sv
module sdq_branch_metrics_tb_top;
   logic clk = 1'b0;
   logic rst_n;
   logic in_valid;
   logic clip_wide;
   logic signed [7:0] sample_a;
   logic signed [7:0] sample_b;
   logic out_valid;
   logic [4:0] bm_00, bm_01, bm_10, bm_11;
   logic [5:0] lbl_state;
   logic lbl_input;
   logic [1:0] lbl_code;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sdq_branch_metrics dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .clip_wide(clip_wide),
      .sample_a(sample_a), .sample_b(sample_b), .out_valid(out_valid),
      .bm_00(bm_00), .bm_01(bm_01), .bm_10(bm_10), .bm_11(bm_11),
      .lbl_state(lbl_state), .lbl_input(lbl_input), .lbl_code(lbl_code)
   );

   function automatic int exp_q(input int x, input int wide);
      int lim = wide ? 32 : 16;
      int t = x + lim;
      int q;
      if (t < 0) return 0;
      q = (t * 16) / (2 * lim);
      return (q > 15) ? 15 : q;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int last00, last01, last10, last11;
      rst_n = 1'b0; in_valid = 1'b0; clip_wide = 1'b0;
      sample_a = '0; sample_b = '0; lbl_state = '0; lbl_input = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check("R1 valid in reset", int'(out_valid), 0);
      check("R1 metrics in reset", int'(bm_00) + int'(bm_01) + int'(bm_10) + int'(bm_11), 0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 valid after release", int'(out_valid), 0);
      check("R1 metric after release", int'(bm_11), 0);

      // Back-to-back sweep over every sample value in both clip settings
      for (int w = 0; w < 2; w++) begin
         for (int x = -128; x < 128; x++) begin
            int xb, qa, qb;
            string rq;
            xb = int'($signed(8'(x * 37 + 11)));
            @(negedge clk);
            in_valid = 1'b1; clip_wide = w[0];
            sample_a = 8'(x); sample_b = 8'(xb);
            qa = exp_q(x, w); qb = exp_q(xb, w);
            rq = w ? "R4" : "R3";
            @(posedge clk); #1;
            check("R2 valid back-to-back", int'(out_valid), 1);
            check({rq, " R5 R6 bm_00"}, int'(bm_00), qa + qb);
            check({rq, " R5 R6 bm_01"}, int'(bm_01), qa + (15 - qb));
            check({rq, " R5 R6 bm_10"}, int'(bm_10), (15 - qa) + qb);
            check({rq, " R5 R6 bm_11"}, int'(bm_11), 30 - qa - qb);
            check("R7 pair sum", int'(bm_01) + int'(bm_10), 30);
         end
      end
      last00 = int'(bm_00); last01 = int'(bm_01);
      last10 = int'(bm_10); last11 = int'(bm_11);

      // Idle cycles with changing samples
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         in_valid = 1'b0; clip_wide = i[0];
         sample_a = 8'(-100 + 70 * i); sample_b = 8'(90 - 60 * i);
         @(posedge clk); #1;
         check("R2 valid drops", int'(out_valid), 0);
         check("R8 bm_00 held", int'(bm_00), last00);
         check("R8 bm_01 held", int'(bm_01), last01);
         check("R8 bm_10 held", int'(bm_10), last10);
         check("R8 bm_11 held", int'(bm_11), last11);
      end

      // Exact clip boundaries, then one idle cycle between inputs
      @(negedge clk);
      in_valid = 1'b1; clip_wide = 1'b0; sample_a = 8'sd16; sample_b = -8'sd16;
      @(posedge clk); #1;
      check("R3 +L saturates, -L zero", int'(bm_10), 0);
      @(negedge clk); in_valid = 1'b0;
      @(posedge clk); #1;
      check("R2 single pulse", int'(out_valid), 0);
      @(negedge clk);
      in_valid = 1'b1; clip_wide = 1'b1; sample_a = 8'sd31; sample_b = -8'sd32;
      @(posedge clk); #1;
      check("R4 near +L and at -L", int'(bm_10), 0);
      check("R4 bm_01 edge", int'(bm_01), 30);
      @(negedge clk); in_valid = 1'b0;

      // Every branch label
      for (int s = 0; s < 64; s++) begin
         for (int u = 0; u < 2; u++) begin
            logic [5:0] sv;
            int c0, c1;
            sv = 6'(s);
            c0 = u ^ int'(sv[4]) ^ int'(sv[3]) ^ int'(sv[1]) ^ int'(sv[0]);
            c1 = u ^ int'(sv[5]) ^ int'(sv[4]) ^ int'(sv[3]) ^ int'(sv[0]);
            lbl_state = sv; lbl_input = u[0];
            #1;
            check("R9 branch label", int'(lbl_code), c0 * 2 + c1);
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule